// File: doc/BRIEF.md
# Status Register and Write-Protect Guard

This block sits beside a serial memory command decoder. It keeps the retained control bits of an 8-bit status byte: a pin-enable flag and a two-bit protected-zone selector. It also decides, combinationally, whether the byte at the address currently held by the decoder may be programmed, and whether the status byte may be rewritten. The decoder supplies the write-enable latch, the busy flag of the internal program cycle, the level of the external write-protect pin, a frame-open level (chip select active) and a strobe carrying the status data byte.

A status rewrite is staged when its data byte arrives and committed only when the frame closes. If status-write permission drops while the frame is still open, for example because the protect pin goes low with the pin-enable flag set, the staged rewrite is discarded. Once the frame has closed, the commit goes ahead whatever the pin does. The assembled status byte is registered for read-out and can be read at any time, including during a program cycle.

Top module: `wp_status_guard`

## Requirements
- R1: After synchronous reset the pin-enable flag and zone selector are 0, so the status byte reads 0x00 when the latch and busy inputs are low.
- R2: The status byte places the pin-enable flag at bit 7, zeros at bits 6..4, zone selector high bit at bit 3 and low bit at bit 2, the write-enable latch at bit 1 and the busy flag at bit 0. It appears one clock after its sources change.
- R3: Bit 0 follows the busy input and the status byte stays readable while busy is high.
- R4: Zone selector 00 protects nothing. 01 protects the top quarter, where the two address MSBs are 11. 10 protects the top half, where the address MSB is 1. 11 protects every address.
- R5: With the write-enable latch low, neither array nor status writes are permitted.
- R6: With the latch high and busy low, an array byte is permitted exactly when its address lies outside the protected zone.
- R7: With the latch high and busy low, a status write is permitted unless the pin-enable flag is 1 and the protect pin is low. With the flag at 0 the pin has no effect.
- R8: A committed status write changes only bits 7, 3 and 2, taken from the same bit positions of the data. The other data bits are ignored. The new value is taken when the frame closes.
- R9: A status data strobe that arrives while status writes are not permitted leaves the stored bits unchanged.
- R10: A staged status write is discarded if status-write permission drops while the frame is still open.
- R11: A staged status write whose frame has closed is committed even if the protect pin goes low in the same cycle.
- R12: While busy is high, both permissions are denied and status strobes are ignored.
- R13: Array permission is evaluated from the address presented in the same cycle, so within a page burst each byte is judged on its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_n | input | 1 | Write-protect pin level; low requests protection |
| wel_in | input | 1 | Current write-enable latch |
| busy_in | input | 1 | Internal program cycle in progress |
| frame_open | input | 1 | High while a command frame is selected |
| addr_in | input | AW | Latched target byte address |
| sr_wr_req | input | 1 | One-cycle strobe with the status data byte |
| sr_wr_data | input | 8 | Status data byte |
| array_ok | output | 1 | Array byte at addr_in may be written |
| status_ok | output | 1 | Status byte may be written |
| status_byte | output | 8 | Registered status byte for read-out |

## Verification
The hardest case to reach is a status rewrite that has been staged and is then cancelled before its frame closes. From the ports this shows only as a status byte that does not change. The stimulus opens a frame and delivers a permitted data byte. It then pulls the protect pin low for one cycle with the pin-enable flag set, releases the pin, and closes the frame; the read-out must still show the old bits. The opposite race, with the pin dropping in the same cycle the frame closes, is driven right after and must commit.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int SB_W     = 8;
  localparam int BIT_PEN  = 7;
  localparam int BIT_ZHI  = 3;
  localparam int BIT_ZLO  = 2;
  localparam int BIT_LAT  = 1;
  localparam int BIT_BUSY = 0;

  typedef struct packed {
    logic       pen;
    logic [1:0] zone;
  } wsg_ctrl_t;

  function automatic logic [SB_W-1:0] pack_status(wsg_ctrl_t c, logic lat, logic busy);
    logic [SB_W-1:0] s;
    s = '0;
    s[BIT_PEN]  = c.pen;
    s[BIT_ZHI]  = c.zone[1];
    s[BIT_ZLO]  = c.zone[0];
    s[BIT_LAT]  = lat;
    s[BIT_BUSY] = busy;
    return s;
  endfunction

  function automatic wsg_ctrl_t take_ctrl(logic [SB_W-1:0] d);
    wsg_ctrl_t c;
    c.pen  = d[BIT_PEN];
    c.zone = {d[BIT_ZHI], d[BIT_ZLO]};
    return c;
  endfunction
endpackage

// File: rtl/wsg_zone.sv
module wsg_zone #(
  parameter int AW = 10
) (
  input  logic [1:0]    zone,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int MSB = AW - 1;

  always_comb begin
    case (zone)
      2'b00:   hit = 1'b0;
      2'b01:   hit = addr[MSB] & addr[MSB-1];
      2'b10:   hit = addr[MSB];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wsg_grant.sv
module wsg_grant (
  input  logic lat,
  input  logic busy,
  input  logic pen,
  input  logic lock_n,
  input  logic zone_hit,
  output logic arr_ok,
  output logic sr_ok
);
  logic open_gate;
  logic pin_block;

  always_comb begin
    open_gate = lat & ~busy;
    pin_block = pen & ~lock_n;
    arr_ok    = open_gate & ~zone_hit;
    sr_ok     = open_gate & ~pin_block;
  end
endmodule

// File: rtl/wsg_store.sv
module wsg_store
  import wsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_open,
  input  logic            sr_ok,
  input  logic            wr_req,
  input  logic [SB_W-1:0] wr_data,
  input  logic            lat,
  input  logic            busy,
  output wsg_ctrl_t       ctrl,
  output logic [SB_W-1:0] status_q
);
  wsg_ctrl_t ctrl_q;
  wsg_ctrl_t stage_q;
  logic      pend_q;
  logic      unused_bits;

  assign unused_bits = ^{wr_data[6:4], wr_data[1:0]};
  assign ctrl = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      stage_q  <= '0;
      pend_q   <= 1'b0;
      status_q <= '0;
    end else begin
      status_q <= pack_status(ctrl_q, lat, busy);
      if (pend_q && !frame_open) begin
        ctrl_q <= stage_q;
        pend_q <= 1'b0;
      end else if (frame_open && wr_req && sr_ok) begin
        stage_q <= take_ctrl(wr_data);
        pend_q  <= 1'b1;
      end else if (pend_q && !sr_ok) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R8
  hold_without_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(ctrl_q));

  // R10
  drop_on_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && frame_open && !sr_ok) |=> !pend_q);

  // R2
  zero_field_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[6:4] == 3'b000);
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wsg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_n,
  input  logic          wel_in,
  input  logic          busy_in,
  input  logic          frame_open,
  input  logic [AW-1:0] addr_in,
  input  logic          sr_wr_req,
  input  logic [7:0]    sr_wr_data,
  output logic          array_ok,
  output logic          status_ok,
  output logic [7:0]    status_byte
);
  wsg_ctrl_t ctrl;
  logic      zone_hit;

  wsg_zone #(.AW(AW)) u_zone (
    .zone (ctrl.zone),
    .addr (addr_in),
    .hit  (zone_hit)
  );

  wsg_grant u_grant (
    .lat      (wel_in),
    .busy     (busy_in),
    .pen      (ctrl.pen),
    .lock_n   (lock_n),
    .zone_hit (zone_hit),
    .arr_ok   (array_ok),
    .sr_ok    (status_ok)
  );

  wsg_store u_store (
    .clk        (clk),
    .rst        (rst),
    .frame_open (frame_open),
    .sr_ok      (status_ok),
    .wr_req     (sr_wr_req),
    .wr_data    (sr_wr_data),
    .lat        (wel_in),
    .busy       (busy_in),
    .ctrl       (ctrl),
    .status_q   (status_byte)
  );

  // R4
  full_zone_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.zone == 2'b11) |-> !array_ok);

  // R5
  latch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (array_ok || status_ok) |-> wel_in);

  // R12
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    busy_in |-> !(array_ok || status_ok));
endmodule

// File: tb/wp_status_guard_bench.sv
module wp_status_guard_bench;
  localparam int AW = 10;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lock_n = 1'b1, wel_in = 1'b0, busy_in = 1'b0, frame_open = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          sr_wr_req = 1'b0;
  logic [7:0]    sr_wr_data = '0;
  logic          array_ok, status_ok;
  logic [7:0]    status_byte;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wp_status_guard #(.AW(AW)) u_wp_status_guard (
    .clk(clk), .rst(rst), .lock_n(lock_n), .wel_in(wel_in), .busy_in(busy_in),
    .frame_open(frame_open), .addr_in(addr_in), .sr_wr_req(sr_wr_req),
    .sr_wr_data(sr_wr_data), .array_ok(array_ok), .status_ok(status_ok),
    .status_byte(status_byte));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = {7'b0, array_ok};
        1:       act = {7'b0, status_ok};
        default: act = status_byte;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic sb_check(string req, logic [7:0] exp);
    step(2);
    push(req, 2, exp);
  endtask

  task automatic arr_at(string req, logic [AW-1:0] a, logic exp);
    addr_in = a;
    push(req, 0, {7'b0, exp});
    step();
  endtask

  task automatic wrsr(logic [7:0] d);
    frame_open = 1'b1; step();
    sr_wr_req = 1'b1; sr_wr_data = d; step();
    sr_wr_req = 1'b0; step();
    frame_open = 1'b0; step(3);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    sb_check("R1", 8'h00);
    wel_in = 1'b1;
    sb_check("R2", 8'h02);
    busy_in = 1'b1;
    sb_check("R3", 8'h03);
    push("R12", 0, 8'h00); push("R12", 1, 8'h00); step();
    wrsr(8'h8C);
    sb_check("R12", 8'h03);
    busy_in = 1'b0; wel_in = 1'b0;
    push("R5", 0, 8'h00); push("R5", 1, 8'h00); step();
    wel_in = 1'b1;
    arr_at("R6", 10'h3FF, 1'b1);
    arr_at("R4", 10'h000, 1'b1);
    wrsr(8'h76);                       // only bits 7,3,2 used -> zone 01
    sb_check("R8", 8'h06);
    for (int a = 10'h2FC; a < 10'h304; a++)  // page burst crossing into the zone
      arr_at("R13", a[AW-1:0], a >= 10'h300 ? 1'b0 : 1'b1);
    arr_at("R4", 10'h3FF, 1'b0);
    wrsr(8'h08);                       // zone 10
    sb_check("R8", 8'h0A);
    arr_at("R4", 10'h1FF, 1'b1);
    arr_at("R4", 10'h200, 1'b0);
    wrsr(8'h8C);                       // pen=1, zone 11
    sb_check("R8", 8'h8E);
    arr_at("R4", 10'h000, 1'b0);
    lock_n = 1'b0;
    push("R7", 1, 8'h00); step();
    wrsr(8'h00);
    sb_check("R9", 8'h8E);
    lock_n = 1'b1;
    push("R7", 1, 8'h01); step();
    // staged write cancelled by pin pulse while frame open
    frame_open = 1'b1; step();
    sr_wr_req = 1'b1; sr_wr_data = 8'h00; step();
    sr_wr_req = 1'b0; lock_n = 1'b0; step();
    lock_n = 1'b1; step();
    frame_open = 1'b0; step(3);
    sb_check("R10", 8'h8E);
    // pin drops in the same cycle the frame closes
    frame_open = 1'b1; step();
    sr_wr_req = 1'b1; sr_wr_data = 8'h80; step();
    sr_wr_req = 1'b0; step();
    frame_open = 1'b0; lock_n = 1'b0; step(3);
    sb_check("R11", 8'h82);
    lock_n = 1'b1;
    wrsr(8'h00);
    sb_check("R8", 8'h02);
    lock_n = 1'b0;
    push("R7", 1, 8'h01); step();
    wrsr(8'h04);
    sb_check("R7", 8'h06);
    lock_n = 1'b1; wel_in = 1'b0;
    wrsr(8'h0C);
    sb_check("R9", 8'h04);
    step(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule